// File: doc/BRIEF.md
# Strided Block DMA Engine

This block copies bytes between a 4 KB on-chip scratch memory and a large external byte memory. The scratch memory has two banks, and the external memory is addressed with 24 bits. A single start strobe launches a transfer. The transfer moves a rectangular region made of one or more rows. Each row is the same whole number of 8-byte units. Between rows, the external side can jump forward by a programmable stride, while the scratch side stays packed. A direction input selects which memory is the source.

Both memories are reached through simple synchronous byte ports. A read issued in one cycle returns its data in the next cycle. The engine overlaps reads and writes, so it moves one byte per cycle for the whole transfer. When the copy ends, the engine publishes the final scratch address, the bank and the final external address. It also rewrites its length descriptor to a fixed finished pattern, so that software polling the registers sees where the copy stopped.

Top module: `strided_dma`

## Requirements
- R1: The 32-bit descriptor `len_in` is split into three fields: bits 11:0 hold the row length minus one, bits 19:12 hold the row count minus one, and bits 31:20 hold the external stride. Each row moves (length field + 1) bytes, rounded up to a multiple of 8.
- R2: At start, the engine forces the low 3 bits of the scratch address (bits 11:0) and of the external address to zero. Bit 12 of `loc_addr_in` selects the scratch bank and is driven on `loc_bank` for the whole transfer.
- R3: The engine copies (count field + 1) rows. Inside a row, the scratch byte address wraps modulo 4096.
- R4: After every row except the last, the external base advances by the row length plus the stride. After the last row, it advances by the row length only. The result is kept 8-byte aligned and 24 bits wide.
- R5: After every row, the scratch base advances by the row length, kept 8-byte aligned modulo 4096.
- R6: When `done` pulses, `cur_loc_addr`, `cur_bank` and `cur_ext_addr` show the final scratch base, the bank and the final external base.
- R7: When `done` pulses, `len_rd` reads back with bits 11:0 = 0xFF8, bits 19:12 = 0, and bits 31:20 equal to the stride of the finished transfer.
- R8: With `to_ext`=1, bytes go from scratch to external memory. With `to_ext`=0, bytes go from external to scratch memory. The other memory is left untouched.
- R9: `busy` rises on the edge that samples `start` and stays high until the edge that writes the last byte. `done` is high for exactly the one cycle after that, and never together with `busy`.
- R10: A `start` that arrives while `busy` is high has no effect on the transfer in progress.
- R11: Reads return data one cycle after the request. The engine issues one read per cycle, so a transfer of N bytes keeps `busy` high for N+1 cycles.
- R12: After reset, `busy` and `done` are low, and the current-address outputs and `len_rd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe |
| to_ext | input | 1 | 1: scratch to external, 0: external to scratch |
| loc_addr_in | input | 13 | Scratch byte address (11:0) and bank select (12) |
| ext_addr_in | input | 24 | External byte address |
| len_in | input | 32 | Length, row count and stride descriptor |
| loc_addr | output | 12 | Scratch memory byte address |
| loc_bank | output | 1 | Scratch bank select |
| loc_re | output | 1 | Scratch read request |
| loc_rdata | input | 8 | Scratch read data, one cycle after request |
| loc_we | output | 1 | Scratch write enable |
| loc_wdata | output | 8 | Scratch write data |
| ext_addr | output | 24 | External memory byte address |
| ext_re | output | 1 | External read request |
| ext_rdata | input | 8 | External read data, one cycle after request |
| ext_we | output | 1 | External write enable |
| ext_wdata | output | 8 | External write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_loc_addr | output | 12 | Final scratch base of the last transfer |
| cur_bank | output | 1 | Bank of the last transfer |
| cur_ext_addr | output | 24 | Final external base of the last transfer |
| len_rd | output | 32 | Descriptor readback |

## Verification
For a transfer of N bytes, `busy` is first seen high one cycle after the start edge. It stays high for N+1 cycles, and `done` is due in the very next cycle, together with the current-address outputs and the rewritten descriptor. The bench drives inputs on falling edges and counts `busy` cycles at each falling edge against the N+1 figure. It samples `done` and the published registers at the falling edge where `busy` is first seen low, and confirms `done` has cleared one cycle later. It then compares both memories in full against a bench-side copy built from the descriptor arithmetic.

// File: rtl/strided_dma.sv
module strided_dma #(
  parameter int LAW = 12,
  parameter int EAW = 24,
  parameter int CW  = 8,
  parameter int SW  = 12,
  parameter int ALN = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  to_ext,
  input  logic [LAW:0]          loc_addr_in,
  input  logic [EAW-1:0]        ext_addr_in,
  input  logic [LAW+CW+SW-1:0]  len_in,
  output logic [LAW-1:0]        loc_addr,
  output logic                  loc_bank,
  output logic                  loc_re,
  input  logic [7:0]            loc_rdata,
  output logic                  loc_we,
  output logic [7:0]            loc_wdata,
  output logic [EAW-1:0]        ext_addr,
  output logic                  ext_re,
  input  logic [7:0]            ext_rdata,
  output logic                  ext_we,
  output logic [7:0]            ext_wdata,
  output logic                  busy,
  output logic                  done,
  output logic [LAW-1:0]        cur_loc_addr,
  output logic                  cur_bank,
  output logic [EAW-1:0]        cur_ext_addr,
  output logic [LAW+CW+SW-1:0]  len_rd
);

  localparam int LW  = LAW + CW + SW;
  localparam int RLW = LAW + 1;
  localparam logic [LAW-1:0] LMASK = {{(LAW-ALN){1'b1}}, {ALN{1'b0}}};
  localparam logic [EAW-1:0] EMASK = {{(EAW-ALN){1'b1}}, {ALN{1'b0}}};
  localparam logic [RLW-1:0] RMASK = {{(RLW-ALN){1'b1}}, {ALN{1'b0}}};

  logic           issuing, dir_q, bank_q;
  logic [RLW-1:0] rowlen_q, j_q;
  logic [CW-1:0]  cnt_q, row_q;
  logic [SW-1:0]  skip_q;
  logic [LAW-1:0] lbase, wr_la;
  logic [EAW-1:0] ebase, wr_ea;
  logic           wr_vld, wr_last;

  wire            accept    = start & ~busy;
  wire [RLW-1:0]  rl_new    = ({1'b0, len_in[LAW-1:0]} + RLW'(1 << ALN)) & RMASK;
  wire            last_byte = (j_q == rowlen_q - RLW'(1));
  wire            last_row  = (row_q == cnt_q);
  wire [LAW-1:0]  lcur      = lbase + j_q[LAW-1:0];
  wire [EAW-1:0]  ecur      = ebase + EAW'(j_q);
  wire [EAW-1:0]  estep     = EAW'(rowlen_q) + (last_row ? '0 : EAW'(skip_q));
  wire            finish    = wr_vld & wr_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; issuing <= 1'b0; dir_q <= 1'b0; bank_q <= 1'b0;
      rowlen_q <= '0; j_q <= '0; cnt_q <= '0; row_q <= '0; skip_q <= '0;
      lbase <= '0; ebase <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      issuing  <= 1'b1;
      dir_q    <= to_ext;
      bank_q   <= loc_addr_in[LAW];
      rowlen_q <= rl_new;
      cnt_q    <= len_in[LAW +: CW];
      skip_q   <= len_in[LW-1 -: SW];
      row_q    <= '0;
      j_q      <= '0;
      lbase    <= loc_addr_in[LAW-1:0] & LMASK;
      ebase    <= ext_addr_in & EMASK;
    end else begin
      if (finish) busy <= 1'b0;
      if (issuing) begin
        if (last_byte) begin
          j_q   <= '0;
          lbase <= (lbase + rowlen_q[LAW-1:0]) & LMASK;
          ebase <= (ebase + estep) & EMASK;
          if (last_row) issuing <= 1'b0;
          else          row_q   <= row_q + CW'(1);
        end else begin
          j_q <= j_q + RLW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_vld <= 1'b0; wr_last <= 1'b0; wr_la <= '0; wr_ea <= '0;
    end else begin
      wr_vld  <= issuing;
      wr_last <= issuing & last_byte & last_row;
      wr_la   <= lcur;
      wr_ea   <= ecur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; cur_loc_addr <= '0; cur_bank <= 1'b0; cur_ext_addr <= '0; len_rd <= '0;
    end else begin
      done <= finish;
      if (accept) len_rd <= len_in;
      else if (finish) begin
        cur_loc_addr <= lbase;
        cur_bank     <= bank_q;
        cur_ext_addr <= ebase;
        len_rd       <= {len_rd[LW-1 -: SW], {CW{1'b0}}, LMASK};
      end
    end
  end

  assign loc_bank  = bank_q;
  assign loc_re    = issuing & dir_q;
  assign ext_re    = issuing & ~dir_q;
  assign loc_addr  = dir_q ? lcur : wr_la;
  assign ext_addr  = dir_q ? wr_ea : ecur;
  assign loc_we    = wr_vld & ~dir_q;
  assign ext_we    = wr_vld & dir_q;
  assign loc_wdata = ext_rdata;
  assign ext_wdata = loc_rdata;

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(rowlen_q) && $stable(skip_q) && $stable(dir_q) && $stable(cnt_q)));
  a_r6_aligned_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cur_loc_addr[ALN-1:0] == '0 && cur_ext_addr[ALN-1:0] == '0));
  a_r7_len_rewritten: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_rd[LAW+CW-1:0] == {{CW{1'b0}}, LMASK}));
  a_r11_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_re || ext_re) |=> (loc_we || ext_we));
  a_r8_single_dest: assert property (@(posedge clk) disable iff (!rst_n) !(loc_we && ext_we));

endmodule

// File: tb/tb_strided_dma.sv
module tb_strided_dma;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, to_ext = 1'b0;
  logic [12:0] loc_addr_in = '0;
  logic [23:0] ext_addr_in = '0;
  logic [31:0] len_in = '0;
  logic [11:0] loc_addr; logic loc_bank, loc_re, loc_we; logic [7:0] loc_rdata, loc_wdata;
  logic [23:0] ext_addr; logic ext_re, ext_we; logic [7:0] ext_rdata, ext_wdata;
  logic busy, done, cur_bank; logic [11:0] cur_loc_addr; logic [23:0] cur_ext_addr; logic [31:0] len_rd;

  int checks = 0, fails = 0;
  logic [7:0] lmem [8192]; logic [7:0] xmem [8192];
  logic [7:0] rl [8192];   logic [7:0] rx [8192];

  always #5 clk = ~clk;

  strided_dma dut (.clk, .rst_n, .start, .to_ext, .loc_addr_in, .ext_addr_in, .len_in,
    .loc_addr, .loc_bank, .loc_re, .loc_rdata, .loc_we, .loc_wdata,
    .ext_addr, .ext_re, .ext_rdata, .ext_we, .ext_wdata,
    .busy, .done, .cur_loc_addr, .cur_bank, .cur_ext_addr, .len_rd);

  always @(posedge clk) begin
    if (loc_re) loc_rdata <= lmem[{loc_bank, loc_addr}];
    if (loc_we) lmem[{loc_bank, loc_addr}] <= loc_wdata;
    if (ext_re) ext_rdata <= xmem[ext_addr[12:0]];
    if (ext_we) xmem[ext_addr[12:0]] <= ext_wdata;
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_mem(string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 8192; i++) begin
      if (lmem[i] !== rl[i]) begin bad++; if (first < 0) first = i; end
      if (xmem[i] !== rx[i]) begin bad++; if (first < 0) first = 8192 + i; end
    end
    chk({req, " memory mismatches (first index in actual)"}, bad == 0 ? 0 : first + 1, 0);
  endtask

  task automatic run(bit dir, int la, int ea, int lw, bit poke);
    int bank = (la >> 12) & 1;
    int l = la & 'hFF8;
    int e = ea & 'hFFFFF8;
    int L = ((lw & 'hFFF) + 8) & ~7;
    int cnt = (lw >> 12) & 'hFF;
    int sk = (lw >>> 20) & 'hFFF;
    int n = (cnt + 1) * L;
    int c = 0;
    for (int r = 0; r <= cnt; r++) begin
      for (int j = 0; j < L; j++) begin
        int li = bank * 4096 + ((l + j) & 'hFFF);
        int xi = (e + j) & 'h1FFF;
        if (dir) rx[xi] = rl[li]; else rl[li] = rx[xi];
      end
      e = (e + L + (r == cnt ? 0 : sk)) & 'hFFFFF8;
      l = (l + L) & 'hFF8;
    end
    to_ext = dir; loc_addr_in = 13'(la); ext_addr_in = 24'(ea); len_in = 32'(lw); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      c++;
      if (poke && c == 3) begin
        start = 1'b1; to_ext = ~dir; len_in = 32'h0; loc_addr_in = 13'h1008; ext_addr_in = 24'h40;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R1/R9/R11/R10 busy cycles", c, n + 1);
    chk("R9 done after last write", done, 1);
    chk("R5/R6/R10 final scratch base", cur_loc_addr, l);
    chk("R2/R6 bank", cur_bank, bank);
    chk("R4/R6 final external base", cur_ext_addr, e);
    chk("R7/R10 descriptor readback", len_rd, (longint'(sk) << 20) | 'hFF8);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    cmp_mem("R3/R8/R2/R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin
      lmem[i] = 8'(i * 37 + 11); rl[i] = lmem[i];
      xmem[i] = 8'((i * 91 + 5) ^ (i >> 8)); rx[i] = xmem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 busy reset", busy, 0);
    chk("R12 done reset", done, 0);
    chk("R12 current addresses reset", {cur_bank, cur_loc_addr, cur_ext_addr}, 0);
    chk("R12 descriptor reset", len_rd, 0);
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 6; f++)
        for (int k = 0; k < 3; k++) begin
          int lens [6] = '{0, 3, 7, 8, 15, 20};
          int lw = lens[f] | (k << 12) | (((f * 5 + k * 3) & 'hFFF) << 20);
          int la = ((f * 523 + k * 977 + d * 300) & 'h1FFF) | ((f == 2) ? 'hFF3 : 0);
          int ea = 'hA50000 + f * 211 + k * 1031 + d * 17;
          run(d[0], la, ea, lw, 1'b0);
        end
    run(1'b0, 'h0FF5, 'h123456, 'h0020_0017, 1'b0);
    run(1'b1, 'h1FE8, 'hFFFFF0, 'h0080_1010, 1'b0);
    run(1'b0, 'h1100, 'h000008, 'h0100_30FF, 1'b0);
    run(1'b1, 'h0200, 'h001000, 'h0000_1000, 1'b0);
    run(1'b0, 'h0040, 'h000800, 'h0030_2017, 1'b1);
    run(1'b1, 'h1040, 'h000900, 'h0030_2017, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule